// File: doc/BRIEF.md
# Stereo Serial Audio Port

This block joins a parallel stereo sample interface to a three-wire serial audio link made of a bit clock, a word clock and one data line in each direction. Samples go out on `sd_o` and come in on `sd_i` in the same frame. Both directions keep the most significant bit first. A frame is 64 bit-clock periods long, with 32 periods given to each channel.

A 7-bit configuration word sets the timing. It chooses who drives the clocks, the word-clock polarity, the bit-clock edge, a one-bit data delay, pulse-sync (TDM) framing with a narrow or wide sync pulse, and the 16-bit or 24-bit sample depth. As master, the port divides its system clock to make both link clocks. As slave, it synchronises the incoming clocks into the system clock and locks its frame counter to the word clock. The configuration is meant to change only while reset is held.

A sample pair to send is accepted through a valid/ready handshake and goes out in the next frame that starts. A received pair appears on the parallel outputs with a one-cycle strobe.

Top module: `audio_serial_port`

## Requirements
- R1: When `cfg[0]`=1 (master), `bclk_o` toggles every CLK_DIV/2 system clocks, starting low after reset, and `bclk_oe` and `lrclk_oe` are 1. When `cfg[0]`=0 both enables are 0. After reset `sd_o`, `lrclk_o` and `rx_valid` are 0 and `tx_ready` is 1.
- R2: With `cfg[4]`=0, the left channel uses frame positions 0–31 and the right channel uses positions 32–63. The word clock is low during the left half when `cfg[1]`=0 and high during it when `cfg[1]`=1.
- R3: With the effective bit-clock invert at 0 (`cfg[2]`=0 and `cfg[4]`=0), `sd_o` and a master `lrclk_o` change on falling bit-clock edges and input is sampled on rising edges. With it at 1, all three edges swap.
- R4: Outside TDM, `cfg[3]`=0 puts the MSB at half-frame position 0 and `cfg[3]`=1 puts it at position 1.
- R5: With `cfg[4]`=1, the word clock is a sync pulse that starts at frame position 0. The left slot takes positions 0..W-1 and the right slot takes positions W..2W-1, and `cfg[3]` has no effect.
- R6: With `cfg[4]`=1, the port behaves as if bit-clock invert were 1 and word-clock invert were 0, whatever `cfg[2]` and `cfg[1]` hold.
- R7: In TDM, `cfg[5]`=1 makes the sync pulse last W bit periods and `cfg[5]`=0 makes it last one period. Outside TDM, `cfg[5]` has no effect.
- R8: W is 24 only when `cfg[4]`=1 and `cfg[6]`=1, and 16 otherwise. Samples are right-justified in the 24-bit ports. In 16-bit operation, bits 23:16 are not sent and read back as 0.
- R9: Each slot is sent MSB first. Positions outside a sample drive `sd_o` to 0, and the port ignores `sd_i` at those positions.
- R10: `rx_valid` pulses for one cycle after the active edge of position 63, carrying the pair received in that frame.
- R11: A pair accepted on `tx_valid`&&`tx_ready` is sent in the next frame that starts. `tx_ready` stays low until that frame starts. A frame with no pair waiting sends zeros.
- R12: In slave mode, the frame counter locks to `lrclk_i` (on its transitions outside TDM, on its rising edge in TDM). Data in both directions follows the same slot rules as in master mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg | input | 7 | Control word: [0] master, [1] word-clock invert, [2] bit-clock invert, [3] data delay, [4] TDM, [5] wide sync, [6] 24-bit depth |
| bclk_i | input | 1 | Bit clock from the link (slave) |
| bclk_o | output | 1 | Generated bit clock (master) |
| bclk_oe | output | 1 | Bit clock pad drive enable |
| lrclk_i | input | 1 | Word clock from the link (slave) |
| lrclk_o | output | 1 | Generated word clock (master) |
| lrclk_oe | output | 1 | Word clock pad drive enable |
| sd_i | input | 1 | Serial data in |
| sd_o | output | 1 | Serial data out |
| tx_left | input | 24 | Left sample to send |
| tx_right | input | 24 | Right sample to send |
| tx_valid | input | 1 | Send pair valid |
| tx_ready | output | 1 | Send pair can be accepted |
| rx_left | output | 24 | Received left sample |
| rx_right | output | 24 | Received right sample |
| rx_valid | output | 1 | One-cycle strobe for a received pair |

## Verification
The assertions check four things on every cycle:
- In master mode, the word clock and the output data change only on the launch edge of the generated bit clock, as the effective polarity sets it.
- The receive strobe never lasts two cycles.
- An accepted send pair lowers `tx_ready`.
- The upper sample bits stay zero in 16-bit operation.

Some behaviour only the bench scenarios can show. The serial layout of each mode needs them: the delay, the slot order, the sync pulse width, and the forced polarities under TDM. So do the zero fill of an empty frame and the round trip of real data. The bench shows these by comparing every cycle against a behavioural model with the output looped back, and by acting as a clock master in slave mode.

// File: rtl/audio_serial_port.sv
module audio_serial_port #(
  parameter int CLK_DIV   = 4,
  parameter int WIDE_W    = 24,
  parameter int NARROW_W  = 16,
  parameter int SLOT_BITS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [6:0]        cfg,
  input  logic              bclk_i,
  output logic              bclk_o,
  output logic              bclk_oe,
  input  logic              lrclk_i,
  output logic              lrclk_o,
  output logic              lrclk_oe,
  input  logic              sd_i,
  output logic              sd_o,
  input  logic [WIDE_W-1:0] tx_left,
  input  logic [WIDE_W-1:0] tx_right,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [WIDE_W-1:0] rx_left,
  output logic [WIDE_W-1:0] rx_right,
  output logic              rx_valid
);
  localparam int PW = $clog2(2 * SLOT_BITS);
  localparam int DW = $clog2(CLK_DIV);
  localparam int IW = $clog2(WIDE_W);

  wire master = cfg[0];
  wire tdm    = cfg[4];
  wire bci    = cfg[2] | tdm;
  wire wci    = cfg[1] & ~tdm;
  wire dly    = cfg[3] & ~tdm;
  wire wide   = cfg[5] & tdm;
  wire [PW-1:0] wid = (cfg[6] & tdm) ? PW'(WIDE_W) : PW'(NARROW_W);

  logic [DW-1:0]     dcnt;
  logic [1:0]        bs, ls2, ds2;
  logic              bprev, lr_prev, hold_vld;
  logic [PW-1:0]     cnt, cnt_nxt;
  logic [WIDE_W-1:0] act_l, act_r, hold_l, hold_r, sh_l, sh_r;

  function automatic logic [PW+1:0] slot_of(input logic [PW-1:0] p, input logic t, input logic d,
                                            input logic [PW-1:0] wd);
    logic [PW-1:0] b;
    logic c, v;
    if (t) begin
      c = (p >= wd);
      b = c ? p - wd : p;
      v = p < (wd << 1);
    end else begin
      c = p[PW-1];
      b = {1'b0, p[PW-2:0]} - {{(PW-1){1'b0}}, d};
      v = ({1'b0, p[PW-2:0]} >= {{(PW-1){1'b0}}, d}) && (b < wd);
    end
    return {v, c, b};
  endfunction

  wire mtog   = (dcnt == DW'(CLK_DIV / 2 - 1));
  wire rise   = master ? (mtog & ~bclk_o) : (bs[1] & ~bprev);
  wire fall   = master ? (mtog & bclk_o) : (~bs[1] & bprev);
  wire launch = bci ? rise : fall;
  wire active = bci ? fall : rise;
  wire ls     = ls2[1];

  always_comb begin
    if (master)              cnt_nxt = cnt + 1'b1;
    else if (tdm)            cnt_nxt = (ls & ~lr_prev) ? '0 : cnt + 1'b1;
    else if (ls != lr_prev)  cnt_nxt = (ls ^ wci) ? PW'(SLOT_BITS) : '0;
    else                     cnt_nxt = cnt + 1'b1;
  end

  wire               fstart = (cnt_nxt == '0);
  wire [WIDE_W-1:0]  nl = fstart ? (hold_vld ? hold_l : '0) : act_l;
  wire [WIDE_W-1:0]  nr = fstart ? (hold_vld ? hold_r : '0) : act_r;
  wire [PW+1:0]      ts = slot_of(cnt_nxt, tdm, dly, wid);
  wire [WIDE_W-1:0]  tsamp = ts[PW] ? nr : nl;
  wire [IW-1:0]      ttap = IW'(wid - PW'(1) - ts[PW-1:0]);
  wire               tbit = ts[PW+1] & tsamp[ttap];
  wire               lr_nxt = tdm ? (wide ? (cnt_nxt < wid) : (cnt_nxt == '0)) : (cnt_nxt[PW-1] ^ wci);
  wire [PW+1:0]      rs = slot_of(cnt, tdm, dly, wid);
  wire [IW-1:0]      rtap = IW'(wid - PW'(1) - rs[PW-1:0]);
  wire               din = master ? sd_i : ds2[1];

  assign bclk_oe  = master;
  assign lrclk_oe = master;
  assign tx_ready = ~hold_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt <= '0;  bclk_o <= 1'b0;
      bs <= '0;  ls2 <= '0;  ds2 <= '0;  bprev <= 1'b0;  lr_prev <= 1'b0;
      cnt <= '1;  lrclk_o <= 1'b0;  sd_o <= 1'b0;
      act_l <= '0;  act_r <= '0;  hold_l <= '0;  hold_r <= '0;  hold_vld <= 1'b0;
      sh_l <= '0;  sh_r <= '0;  rx_left <= '0;  rx_right <= '0;  rx_valid <= 1'b0;
    end else begin
      dcnt  <= mtog ? '0 : dcnt + 1'b1;
      if (mtog) bclk_o <= ~bclk_o;
      bs    <= {bs[0], bclk_i};
      ls2   <= {ls2[0], lrclk_i};
      ds2   <= {ds2[0], sd_i};
      bprev <= bs[1];
      rx_valid <= 1'b0;
      if (launch) begin
        cnt     <= cnt_nxt;
        lr_prev <= ls;
        lrclk_o <= lr_nxt;
        sd_o    <= tbit;
        if (fstart) begin
          act_l    <= nl;
          act_r    <= nr;
          hold_vld <= 1'b0;
        end
      end
      if (tx_valid && !hold_vld) begin
        hold_l   <= tx_left;
        hold_r   <= tx_right;
        hold_vld <= 1'b1;
      end
      if (active) begin
        if (rs[PW+1]) begin
          if (rs[PW]) sh_r[rtap] <= din;
          else        sh_l[rtap] <= din;
        end
        if (cnt == '1) begin
          rx_left  <= sh_l;
          rx_right <= sh_r;
          rx_valid <= 1'b1;
          sh_l     <= '0;
          sh_r     <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/audio_serial_port_sva.sv
module audio_serial_port_sva #(
  parameter int WIDE_W   = 24,
  parameter int NARROW_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [6:0]        cfg,
  input logic              bclk_o,
  input logic              lrclk_o,
  input logic              sd_o,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [WIDE_W-1:0] rx_left,
  input logic [WIDE_W-1:0] rx_right,
  input logic              rx_valid
);
  assert_lr_on_launch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[0] && (lrclk_o != $past(lrclk_o))) |->
      ((bclk_o != $past(bclk_o)) && (bclk_o == (cfg[2] | cfg[4]))));

  assert_sd_on_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[0] && (sd_o != $past(sd_o))) |->
      ((bclk_o != $past(bclk_o)) && (bclk_o == (cfg[2] | cfg[4]))));

  assert_rx_single_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_tx_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  assert_narrow_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !(cfg[4] && cfg[6])) |->
      ((rx_left[WIDE_W-1:NARROW_W] == '0) && (rx_right[WIDE_W-1:NARROW_W] == '0)));
endmodule

bind audio_serial_port audio_serial_port_sva #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .cfg(cfg), .bclk_o(bclk_o), .lrclk_o(lrclk_o), .sd_o(sd_o),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_left(rx_left), .rx_right(rx_right),
  .rx_valid(rx_valid)
);

// File: tb/audio_serial_port_tb_top.sv
`timescale 1ns/1ps
module audio_serial_port_tb_top;
  localparam int DIV = 4;
  localparam int SHALF = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [6:0] cfg = '0;
  logic bclk_i = 1'b0, lrclk_i = 1'b0, sd_drv = 1'b0, loop = 1'b0;
  logic [23:0] tx_left = '0, tx_right = '0;
  logic tx_valid = 1'b0;
  wire bclk_o, bclk_oe, lrclk_o, lrclk_oe, sd_o, tx_ready, rx_valid;
  wire [23:0] rx_left, rx_right;
  wire sd_i = loop ? sd_o : sd_drv;

  int checks = 0, errors = 0, nstrobe = 0, ncap = 0;
  string tag = "R1";
  bit cmp_en = 0, fired = 0;
  logic [23:0] ql[$], qr[$];
  logic [23:0] cap_l, cap_r;

  always #2.5 clk = ~clk;

  audio_serial_port #(.CLK_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .bclk_i(bclk_i), .bclk_o(bclk_o), .bclk_oe(bclk_oe),
    .lrclk_i(lrclk_i), .lrclk_o(lrclk_o), .lrclk_oe(lrclk_oe), .sd_i(sd_i), .sd_o(sd_o),
    .tx_left(tx_left), .tx_right(tx_right), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid));

  function automatic bit e_bci(); return cfg[2] | cfg[4]; endfunction
  function automatic int ewid(); return (cfg[4] && cfg[6]) ? 24 : 16; endfunction
  function automatic logic [23:0] msk(logic [23:0] v);
    return (ewid() == 24) ? v : {8'h00, v[15:0]};
  endfunction
  function automatic bit exp_lr(int p);
    if (cfg[4]) return cfg[5] ? (p < ewid()) : (p == 0);
    return (p >= 32) ^ cfg[1];
  endfunction
  function automatic bit exp_bit(int p, logic [23:0] l, logic [23:0] r);
    int w, b, ch;
    w = ewid();
    if (cfg[4]) begin
      if (p >= 2 * w) return 1'b0;
      ch = (p >= w) ? 1 : 0;
      b = p - ch * w;
    end else begin
      ch = (p >= 32) ? 1 : 0;
      b = (p % 32) - int'(cfg[3]);
      if (b < 0 || b >= 16) return 1'b0;
    end
    return (ch == 1) ? r[w-1-b] : l[w-1-b];
  endfunction

  always @(posedge clk) fired <= rst_n && tx_valid && tx_ready;
  always @(negedge clk) begin
    if (fired) tx_valid = 1'b0;
    if (rst_n && !tx_valid && ql.size() > 0) begin
      tx_left = ql.pop_front();
      tx_right = qr.pop_front();
      tx_valid = 1'b1;
    end
  end

  int ph, mpos;
  bit mb, elr, esd, erxv, hv;
  logic [23:0] hl, hr, al, ar, erl, err;
  always @(posedge clk) begin
    bit acc;
    acc = tx_valid && tx_ready;
    if (!rst_n) begin
      ph = 0; mpos = 63; mb = 0; elr = 0; esd = 0; erxv = 0; hv = 0;
      al = '0; ar = '0; hl = '0; hr = '0; erl = '0; err = '0;
    end else begin
      erxv = 0;
      ph++;
      if (ph == DIV / 2) begin
        ph = 0;
        mb = !mb;
        if (mb == e_bci()) begin
          mpos = (mpos + 1) % 64;
          if (mpos == 0) begin
            al = hv ? hl : '0;
            ar = hv ? hr : '0;
            hv = 0;
          end
          elr = exp_lr(mpos);
          esd = exp_bit(mpos, al, ar);
        end else if (mpos == 63) begin
          erxv = 1;
          erl = msk(al);
          err = msk(ar);
        end
      end
      if (acc) begin hl = tx_left; hr = tx_right; hv = 1; end
    end
  end

  task automatic chk(bit ok, string req, string what, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rx_valid) begin cap_l = rx_left; cap_r = rx_right; ncap++; end
    if (cmp_en) begin
      if (rx_valid) nstrobe++;
      chk(bclk_o === mb, "R1", "bclk_o", 48'(bclk_o), 48'(mb));
      chk(lrclk_o === elr, tag, "lrclk_o", 48'(lrclk_o), 48'(elr));
      chk(sd_o === esd, {"R9 ", tag}, "sd_o", 48'(sd_o), 48'(esd));
      chk(tx_ready === !hv, "R11", "tx_ready", 48'(tx_ready), 48'(!hv));
      chk(rx_valid === erxv, "R10", "rx_valid", 48'(rx_valid), 48'(erxv));
      if (erxv)
        chk({rx_left, rx_right} === {erl, err}, {"R10 ", tag}, "rx pair",
            {rx_left, rx_right}, {erl, err});
    end
  end

  task automatic do_reset(logic [6:0] c);
    rst_n = 1'b0;
    cfg = c;
    bclk_i = !(c[2] | c[4]);
    lrclk_i = 1'b0;
    sd_drv = 1'b0;
    repeat (4) @(negedge clk);
    chk({bclk_oe, lrclk_oe} === {2{c[0]}}, "R1", "pad enables", 48'({bclk_oe, lrclk_oe}), 48'({2{c[0]}}));
    chk({sd_o, lrclk_o, rx_valid, tx_ready} === 4'b0001, "R1", "reset outputs",
        48'({sd_o, lrclk_o, rx_valid, tx_ready}), 48'(4'b0001));
  endtask

  task automatic run_master(logic [6:0] c, string t, logic [23:0] seed);
    loop = 1'b1;
    tag = t;
    do_reset(c);
    cmp_en = 1;
    nstrobe = 0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      ql.push_back(seed ^ (24'h13579B * (k + 1)));
      qr.push_back(~seed + 24'h2468AC * k);
    end
    repeat (5 * 64 * DIV + 20) @(negedge clk);
    cmp_en = 0;
    @(negedge clk);
    chk(nstrobe >= 5, "R10", "strobe count", 48'(nstrobe), 48'(5));
  endtask

  task automatic run_slave(logic [6:0] c, string t, logic [23:0] tl, logic [23:0] tr,
                           logic [23:0] sl, logic [23:0] sr);
    bit lvl;
    int bad;
    loop = 1'b0;
    tag = t;
    do_reset(c);
    lvl = c[2] | c[4];
    @(negedge clk);
    rst_n = 1'b1;
    ql.push_back(tl);
    qr.push_back(tr);
    repeat (6) @(negedge clk);
    for (int f = 0; f < 3; f++) begin
      bad = 0;
      for (int p = 0; p < 64; p++) begin
        bclk_i = lvl;
        lrclk_i = exp_lr(p);
        sd_drv = exp_bit(p, sl, sr);
        repeat (SHALF) @(negedge clk);
        if (sd_o !== (f == 0 ? exp_bit(p, tl, tr) : 1'b0)) bad++;
        bclk_i = !lvl;
        repeat (SHALF) @(negedge clk);
      end
      chk(bad == 0, t, "slave transmit mismatches", 48'(bad), 48'(0));
    end
    repeat (16) @(negedge clk);
    chk(ncap >= 3, t, "slave strobes", 48'(ncap), 48'(3));
    chk({cap_l, cap_r} === {msk(sl), msk(sr)}, t, "slave receive", {cap_l, cap_r}, {msk(sl), msk(sr)});
  endtask

  initial begin
    run_master(7'b0001001, "R4", 24'hA5C30F);
    run_master(7'b0000011, "R2", 24'h5A3CF0);
    run_master(7'b0000101, "R3", 24'h0F1E2D);
    run_master(7'b0010101, "R5", 24'hC0FFEE);
    run_master(7'b1110101, "R7", 24'h9ABCDE);
    run_master(7'b1011011, "R6", 24'h7E57A1);
    run_master(7'b1100001, "R8", 24'hFEDCBA);
    ncap = 0;
    run_slave(7'b0001000, "R12", 24'h00B00C, 24'h00D00E, 24'h12C9A5, 24'h3D5E71);
    ncap = 0;
    run_slave(7'b1010100, "R12", 24'hA1B2C3, 24'h4D5E6F, 24'hF0E1D2, 24'h0C3B5A);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog expired: actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule